// File: doc/BRIEF.md
# Resynchronizing UART Transmitter

This block serialises one byte at a time onto an asynchronous line. A byte arrives through a one-cycle write strobe. The block then sends a low start bit, eight data positions with the least significant bit first, and two high stop bits. Each serial bit lasts sixteen pulses of an external baud tick. The tick is a single-cycle enable in the system clock domain, typically the output pulse of a timer. An internal counter divides it by sixteen.

Each write clears that counter and begins a new frame at once. A write that lands while a frame is still going out drops the old character with no protection. Software uses this on purpose: it writes zero bytes more often than a frame can finish, which holds the line low as a break. A parity-enable input, captured at the write, replaces the eighth data position with an odd parity bit computed over the lower seven bits. When the second stop bit has run its full sixteen ticks, the block raises a one-cycle completion pulse and the line rests high until the next write.

Top module: `uart_resync_tx`

## Requirements
- R1: After reset and between frames the serial output is high and the completion output is low.
- R2: Every serial bit lasts exactly 16 ticks. The completion pulse appears on the clock edge of the 176th tick counted after the write edge, and not before.
- R3: A write clears the prescaler. The output is low (start bit) in the cycle right after the write edge. A tick in the same cycle as the write is not counted.
- R4: A frame is 11 positions in this order: a start bit at 0, data bits D0 to D7 least significant first, then two stop bits at 1.
- R5: With parity enabled at the write, position 8 of the frame (the D7 slot) carries the complement of the XOR of D6..D0, so the eight data positions hold an odd number of ones.
- R6: With parity disabled at the write, all eight data bits go out unchanged, D7 included.
- R7: The completion output is high for exactly one cycle, at the end of the second stop bit. The output is high in that cycle and stays high afterwards.
- R8: A write during a frame abandons it. No completion pulse is given for the abandoned frame, and the new frame is timed from the new write.
- R9: Zero bytes written every 100 ticks keep the output low with no completion pulse. After the last such write, one pulse follows at the end of that frame and the line returns high.
- R10: Ticks with no write pending leave the output high and raise no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Baud tick, one-cycle enable |
| wr_en_i | input | 1 | Transmit buffer write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| par_en_i | input | 1 | Odd parity replaces D7 when high, sampled at the write |
| txd_o | output | 1 | Serial output line, high when idle |
| tx_done_o | output | 1 | One-cycle pulse when a frame has fully gone out |

## Verification
A wrong prescaler count moves every bit boundary. The line is therefore sampled on the last tick of each bit, and the completion pulse is checked on its exact tick, so a slip of one tick shows up within the first bit or at the end of the frame. A wrong frame index or shift register state gives a wrong value at one of the eleven sample points, so it is visible within sixteen ticks. A sequencer that fails to drop its frame on a rewrite produces a stray completion pulse or a high level inside the aborted and break windows, where the line is watched on every cycle.

// File: rtl/uart_rtx_pkg.sv
package uart_rtx_pkg;

  // Section of the frame being driven onto the line.
  typedef enum logic [1:0] {
    SEG_START = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STOP  = 2'd2
  } seg_e;

  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_OVERSMP   = 16;
  localparam int unsigned DEF_STOP_BITS = 2;

endpackage

// File: rtl/uart_rtx_prescale.sv
module uart_rtx_prescale #(
  parameter int unsigned DIV = 16,
  parameter int unsigned CW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);

  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  assign adv    = run_i & tick_i & ~clear_i;
  assign wrap_o = adv & (cnt_q == TOP);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/uart_rtx_frame_seq.sv
module uart_rtx_frame_seq
  import uart_rtx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STOP_BITS = 2,
  parameter int unsigned FRAME_LEN = 1 + DATA_W + STOP_BITS,
  parameter int unsigned IW        = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output seg_e          seg_o,
  output logic          done_o
);

  localparam logic [IW-1:0] LAST_IDX  = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] LAST_DATA = IW'(DATA_W);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (load_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && step_i) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    if (idx_q == '0) begin
      seg_o = SEG_START;
    end else if (idx_q <= LAST_DATA) begin
      seg_o = SEG_DATA;
    end else begin
      seg_o = SEG_STOP;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

endmodule

// File: rtl/uart_rtx_bitpath.sv
module uart_rtx_bitpath
  import uart_rtx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter bit          HAS_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              shift_i,
  input  logic              busy_i,
  input  seg_e              seg_i,
  output logic              txd_o
);

  logic [DATA_W-1:0] fill;
  logic [DATA_W-1:0] sh_q, sh_d;

  // Byte as it will appear on the line, parity slot already resolved.
  generate
    if (HAS_PARITY) begin : g_par
      logic odd_bit;
      assign odd_bit = ~(^data_i[DATA_W-2:0]);
      assign fill    = par_en_i ? {odd_bit, data_i[DATA_W-2:0]} : data_i;
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = par_en_i;
      assign fill       = data_i;
    end
  endgenerate

  always_comb begin
    sh_d = sh_q;
    if (load_i) begin
      sh_d = fill;
    end else if (shift_i) begin
      sh_d = {1'b1, sh_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  always_comb begin
    if (!busy_i) begin
      txd_o = 1'b1;
    end else begin
      unique case (seg_i)
        SEG_START: txd_o = 1'b0;
        SEG_DATA:  txd_o = sh_q[0];
        default:   txd_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/uart_resync_tx.sv
module uart_resync_tx
  import uart_rtx_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned OVERSMP    = DEF_OVERSMP,
  parameter int unsigned STOP_BITS  = DEF_STOP_BITS,
  parameter bit          HAS_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              par_en_i,
  output logic              txd_o,
  output logic              tx_done_o
);

  localparam int unsigned FRAME_LEN = 1 + DATA_W + STOP_BITS;
  localparam int unsigned IW        = $clog2(FRAME_LEN);
  localparam int unsigned CW        = $clog2(OVERSMP);

  logic          busy;
  logic [IW-1:0] bit_idx;
  logic [CW-1:0] pre_cnt;
  logic          bit_wrap;
  logic          data_shift;
  seg_e          seg;

  uart_rtx_prescale #(
    .DIV (OVERSMP),
    .CW  (CW)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (wr_en_i),
    .run_i   (busy),
    .tick_i  (tick_i),
    .cnt_o   (pre_cnt),
    .wrap_o  (bit_wrap)
  );

  uart_rtx_frame_seq #(
    .DATA_W    (DATA_W),
    .STOP_BITS (STOP_BITS),
    .FRAME_LEN (FRAME_LEN),
    .IW        (IW)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_en_i),
    .step_i (bit_wrap),
    .busy_o (busy),
    .idx_o  (bit_idx),
    .seg_o  (seg),
    .done_o (tx_done_o)
  );

  assign data_shift = bit_wrap & (seg == SEG_DATA);

  uart_rtx_bitpath #(
    .DATA_W     (DATA_W),
    .HAS_PARITY (HAS_PARITY)
  ) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (wr_en_i),
    .data_i   (wr_data_i),
    .par_en_i (par_en_i),
    .shift_i  (data_shift),
    .busy_i   (busy),
    .seg_i    (seg),
    .txd_o    (txd_o)
  );

endmodule

// File: rtl/uart_resync_tx_chk.sv
module uart_resync_tx_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FRAME_LEN = 11,
  parameter int unsigned IW        = 4,
  parameter int unsigned CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic          txd_o,
  input logic          tx_done_o,
  input logic          busy,
  input logic [IW-1:0] bit_idx,
  input logic [CW-1:0] pre_cnt
);

  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] LAST_DAT = IW'(DATA_W);

  // R1
  idle_marking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd_o);

  // R3
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (busy && bit_idx == '0 && pre_cnt == '0 && !txd_o));

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> ($stable(pre_cnt) && $stable(bit_idx)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |=> !tx_done_o);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> (!busy && txd_o && $past(busy) && $past(bit_idx) == LAST_IDX));

  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx > LAST_DAT) |-> txd_o);

  // R10
  idle_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en_i) |=> (!busy && !tx_done_o));

endmodule

bind uart_resync_tx uart_resync_tx_chk #(
  .DATA_W    (DATA_W),
  .FRAME_LEN (FRAME_LEN),
  .IW        (IW),
  .CW        (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .txd_o     (txd_o),
  .tx_done_o (tx_done_o),
  .busy      (busy),
  .bit_idx   (bit_idx),
  .pre_cnt   (pre_cnt)
);

// File: tb/uart_resync_tx_bench.sv
module uart_resync_tx_bench;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       par_en;
  logic       txd;
  logic       done;

  logic       force_tick = 1'b0;
  int         ph = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  int         start_cnt = 0;
  int         mon_cnt = 0;
  exp_t       exp_q[$];

  uart_resync_tx u_uart_resync_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .par_en_i  (par_en),
    .txd_o     (txd),
    .tx_done_o (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) ph <= (ph == 2) ? 0 : ph + 1;
  assign tick = (ph == 2) | force_tick;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick) c++;
    end
  endtask

  // Driver: writes one byte and queues the expected eleven line levels.
  task automatic send_frame(input logic [7:0] d, input logic p, input logic ft);
    logic [7:0] w;
    string dtag;
    w    = d;
    dtag = p ? "R5" : "R6";
    if (p) w[7] = ~(^d[6:0]);
    @(negedge clk);
    wr_data    = d;
    par_en     = p;
    wr_en      = 1'b1;
    force_tick = ft;
    exp_q.push_back('{1'b0, "R4"});
    for (int i = 0; i < 8; i++) exp_q.push_back('{w[i], (i == 7) ? dtag : "R4"});
    exp_q.push_back('{1'b1, "R4"});
    exp_q.push_back('{1'b1, "R4"});
    start_cnt++;
    @(negedge clk);
    wr_en      = 1'b0;
    force_tick = 1'b0;
    wait (mon_cnt == start_cnt);
  endtask

  task automatic raw_write(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    par_en  = 1'b0;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Monitor: samples each bit on its last tick and the completion pulse.
  initial begin
    forever begin
      int n;
      exp_t e;
      wait (start_cnt > mon_cnt);
      @(posedge clk);
      @(negedge clk);
      chk("R3", txd, 1'b0);
      n = 0;
      for (int k = 0; k < 11; k++) begin
        while (n < 16 * k + 15) begin
          @(posedge clk);
          if (tick) n++;
        end
        @(negedge clk);
        e = exp_q.pop_front();
        chk(e.tag, txd, e.val);
        chk("R2", done, 1'b0);
      end
      while (n < 176) begin
        @(posedge clk);
        if (tick) n++;
      end
      @(negedge clk);
      chk("R2", done, 1'b1);
      chk("R7", txd, 1'b1);
      @(negedge clk);
      chk("R7", done, 1'b0);
      chk("R7", txd, 1'b1);
      mon_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic bad;
    int   pulses;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    par_en  = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", txd, 1'b1);
    chk("R1", done, 1'b0);
    rst_n = 1'b1;

    // R10: ticks alone do nothing
    bad = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || done !== 1'b0) bad = 1'b1;
    end
    chk("R10", bad, 1'b0);

    send_frame(8'hA5, 1'b0, 1'b0);
    send_frame(8'h3C, 1'b1, 1'b0);
    send_frame(8'h7F, 1'b1, 1'b0);
    send_frame(8'h80, 1'b1, 1'b0);
    send_frame(8'hFF, 1'b0, 1'b0);
    send_frame(8'h00, 1'b1, 1'b0);
    // R3: tick in the write cycle is ignored
    send_frame(8'h5A, 1'b0, 1'b1);
    send_frame(8'hC1, 1'b1, 1'b1);

    // R1: line rests high after a frame
    bad = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || done !== 1'b0) bad = 1'b1;
    end
    chk("R1", bad, 1'b0);

    // R8: abandoned frame gives no pulse, new frame timed from rewrite
    raw_write(8'h55);
    bad = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done !== 1'b0) bad = 1'b1;
    end
    chk("R8", bad, 1'b0);
    send_frame(8'hC3, 1'b0, 1'b0);
    raw_write(8'hF0);
    wait_ticks(170);
    send_frame(8'h96, 1'b1, 1'b0);

    // R9: break by repeated zero writes
    bad = 1'b0;
    for (int w = 0; w < 5; w++) begin
      int c = 0;
      raw_write(8'h00);
      while (c < 100) begin
        @(posedge clk);
        if (tick) c++;
        @(negedge clk);
        if (txd !== 1'b0 || done !== 1'b0) bad = 1'b1;
      end
    end
    chk("R9", bad, 1'b0);
    pulses = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (done === 1'b1) pulses++;
    end
    chk("R9", (pulses == 1), 1'b1);
    chk("R9", txd, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule